// File: doc/BRIEF.md
# MSI Doorbell Pending-Status Bank

This block terminates message-signalled interrupt writes that land on one doorbell location. Each written data word carries a vector number: its low bits choose one of several shared 32-bit pending-status words, and the bits above choose an interrupt index within that word's window of sources. The chosen pending bit is set, and every status word drives its own level-sensitive interrupt line toward an upstream interrupt controller, so one doorbell fans out to a small set of parent interrupts.

Software services a line by reading the matching status word through a simple read port. The read returns the pending bits with the bytes swapped into big-endian order and clears those bits in the same cycle. A doorbell that arrives during that read still lands. Two layouts are selected by parameter: a full layout, where each word owns all 32 bits, and a narrow layout, where each word owns an 8-bit window and the windows step downward through the byte lanes. Malformed doorbells are dropped and flagged.

Top module: `msi_doorbell_bank`

## Requirements
- R1: A doorbell data word is decoded as select = data[SEL_W-1:0] and index = data >> SEL_W; a valid doorbell sets exactly one pending bit in status word number select and nothing else.
- R2: In full layout (NARROW=0) each word has a 32-bit window and index i sets bit 31-i, so index 0 sets bit 31.
- R3: In narrow layout (NARROW=1) word n owns bits 32-8(n+1) up to 31-8n, and index i sets bit 31-8n-i.
- R4: Status word n is read at byte address BASE+4n, with BASE 0x04 in full layout and 0x10 in narrow layout; any unaligned or out-of-range read address returns 0 and clears nothing.
- R5: Read data is byte-swapped: status bits [7:0] appear on rd_data[31:24], [15:8] on [23:16], [23:16] on [15:8] and [31:24] on [7:0].
- R6: Read data appears on rd_data in the cycle after rd_en is sampled and holds until the next read; the read clears the word it returns.
- R7: A doorbell sampled in the same cycle as a clearing read of the same word leaves its bit pending afterwards; it is absent from that read's data.
- R8: irq_o[n] is high exactly while status word n holds any pending bit.
- R9: A doorbell whose select is NUM_REGS or above, or whose index is the window size or above, changes no status and raises db_err for the single following cycle.
- R10: While reset is asserted, and until the first doorbell after it, all status bits, irq_o, db_err and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| db_valid | input | 1 | Doorbell write strobe |
| db_data | input | DATA_W | Doorbell data word carrying the vector |
| rd_en | input | 1 | Status read strobe (read clears) |
| rd_addr | input | ADDR_W | Byte address of the status word to read |
| rd_data | output | 32 | Big-endian status word from the last read |
| irq_o | output | NUM_REGS | One level interrupt per status word |
| db_err | output | 1 | One-cycle flag for a dropped doorbell |

## Verification
The bench builds two instances side by side from the same stimulus: one in full layout with a 3-bit select and eight words, one in narrow layout with a 2-bit select and four words. Sharing stimulus means one data word lands at different bits, or is rejected, depending on the layout, and this exercises both decode rules and both address maps in every cycle. Directed phases reach index 0 and the last index of every word, reads of every address from 0x00 to 0x2F, and a collision between a read and a doorbell on the same word. A long random phase then mixes valid, out-of-range and colliding traffic.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  // Reverse the byte order of a 32-bit status word for the read port.
  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Lowest bit of the source window owned by status word n.
  function automatic int unsigned win_lo(input bit narrow, input int unsigned n,
                                         input int unsigned win);
    return narrow ? (32 - (n + 1) * win) : 0;
  endfunction

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned WIN      = 32,
  parameter bit          NARROW   = 1'b0,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                         db_valid,
  input  logic [DATA_W-1:0]            db_data,
  output logic [NUM_REGS-1:0][31:0]    set_mask,
  output logic                         bad
);
  import msi_db_pkg::*;

  localparam int unsigned IDX_W = DATA_W - SEL_W;

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx;
  logic [4:0]       idx_lo;
  logic             in_range;

  assign sel      = db_data[SEL_W-1:0];
  assign idx      = db_data[DATA_W-1:SEL_W];
  assign idx_lo   = idx[4:0];
  assign in_range = (32'(sel) < NUM_REGS) && (idx < IDX_W'(WIN));
  assign bad      = db_valid && !in_range;

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_word
    localparam int unsigned HI = win_lo(NARROW, n, WIN) + WIN - 1;
    logic [31:0] hit_w;
    always_comb begin
      hit_w = '0;
      if (db_valid && in_range && (sel == SEL_W'(n)))
        hit_w = 32'd1 << (5'(HI) - idx_lo);
    end
    assign set_mask[n] = hit_w;
  end

endmodule

// File: rtl/msi_status_word.sv
module msi_status_word #(
  parameter int unsigned LO  = 0,
  parameter int unsigned WIN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] set_bits,
  input  logic        clr,
  output logic [31:0] status_o,
  output logic        irq_o
);
  localparam logic [31:0] WMASK = 32'(((64'd1 << WIN) - 64'd1) << LO);

  logic [31:0] st_q;
  logic [31:0] st_d;
  logic        st_en;

  always_comb begin
    st_en = clr || (|set_bits);
    st_d  = (clr ? 32'd0 : st_q) | (set_bits & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (st_en)  st_q <= st_d;
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & WMASK);

endmodule

// File: rtl/msi_rd_port.sv
module msi_rd_port #(
  parameter int unsigned NUM_REGS = 8,
  parameter bit          NARROW   = 1'b0,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [NUM_REGS-1:0][31:0] status_all,
  output logic [NUM_REGS-1:0]       clr_o,
  output logic [31:0]               rd_data
);
  import msi_db_pkg::*;

  localparam int unsigned BASE  = NARROW ? 16 : 4;
  localparam int unsigned LIMIT = BASE + 4 * NUM_REGS;

  logic              in_win;
  logic [ADDR_W-1:0] off;
  logic [31:0]       word;
  logic [31:0]       rd_d;
  logic [31:0]       rd_q;

  assign in_win = rd_en && (rd_addr[1:0] == 2'b00) &&
                  (32'(rd_addr) >= BASE) && (32'(rd_addr) < LIMIT);
  assign off    = rd_addr - ADDR_W'(BASE);

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_sel
    assign clr_o[n] = in_win && (32'(off >> 2) == n);
  end

  always_comb begin
    word = '0;
    for (int n = 0; n < NUM_REGS; n++)
      if (clr_o[n]) word = word | status_all[n];
    rd_d = bswap32(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned NUM_REGS = 8,
  parameter bit          NARROW   = 1'b0,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                db_valid,
  input  logic [DATA_W-1:0]   db_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic [NUM_REGS-1:0] irq_o,
  output logic                db_err
);
  import msi_db_pkg::*;

  localparam int unsigned WIN = NARROW ? 8 : 32;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NUM_REGS-1:0][31:0] set_mask;
  logic [NUM_REGS-1:0][31:0] status_all;
  logic [NUM_REGS-1:0]       clr;
  logic                      bad;
  logic                      err_d;
  logic                      err_q;

  msi_db_decode #(
    .SEL_W(SEL_W), .NUM_REGS(NUM_REGS), .WIN(WIN),
    .NARROW(NARROW), .DATA_W(DATA_W)
  ) u_decode (
    .db_valid (db_valid),
    .db_data  (db_data),
    .set_mask (set_mask),
    .bad      (bad)
  );

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_status
    msi_status_word #(
      .LO  (win_lo(NARROW, n, WIN)),
      .WIN (WIN)
    ) u_word (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .set_bits (set_mask[n]),
      .clr      (clr[n]),
      .status_o (status_all[n]),
      .irq_o    (irq_o[n])
    );
  end

  msi_rd_port #(
    .NUM_REGS(NUM_REGS), .NARROW(NARROW), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .status_all (status_all),
    .clr_o      (clr),
    .rd_data    (rd_data)
  );

  assign err_d = bad;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign db_err = err_q;

endmodule

// File: rtl/msi_doorbell_bank_chk.sv
module msi_doorbell_bank_chk #(
  parameter int unsigned NUM_REGS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                db_valid,
  input logic                rd_en,
  input logic                db_err,
  input logic [NUM_REGS-1:0] irq_o,
  input logic [31:0]         rd_data
);

  // an error flag always follows a doorbell attempt
  p_err_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |-> $past(db_valid));

  // a dropped doorbell raises no interrupt line
  p_bad_keeps_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (db_err && !$past(rd_en)) |-> $stable(irq_o));

  // a line can only rise after a doorbell
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o)) != '0) |-> $past(db_valid));

  // a line can only fall after a clearing read
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_o & $past(irq_o)) != '0) |-> $past(rd_en));

  // read data holds between reads
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .db_valid (db_valid),
  .rd_en    (rd_en),
  .db_err   (db_err),
  .irq_o    (irq_o),
  .rd_data  (rd_data)
);

// File: tb/msi_doorbell_bank_tb.sv
`timescale 1ns/1ps
module msi_doorbell_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        db_valid;
  logic [31:0] db_data;
  logic        rd_en;
  logic [7:0]  rd_addr;

  logic [31:0] rd_a, rd_b;
  logic [7:0]  irq_a;
  logic [3:0]  irq_b;
  logic        err_a, err_b;

  always #2.5 clk = ~clk;

  msi_doorbell_bank #(.SEL_W(3), .NUM_REGS(8), .NARROW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_data(db_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_a), .irq_o(irq_a), .db_err(err_a));

  msi_doorbell_bank #(.SEL_W(2), .NUM_REGS(4), .NARROW(1'b1)) u_dut_nar (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_data(db_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_b), .irq_o(irq_b), .db_err(err_b));

  // reference model state, index 0 = full layout, 1 = narrow layout
  int          cfg_selw [2] = '{3, 2};
  int          cfg_nar  [2] = '{0, 1};
  int          cfg_nreg [2] = '{8, 4};
  logic [31:0] m_st  [2][8];
  logic [31:0] m_rd  [2];
  logic        m_err [2];

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_tag = "R10";

  function automatic logic [31:0] be_swap(input logic [31:0] w);
    logic [31:0] o;
    for (int b = 0; b < 32; b++) o[(3 - b / 8) * 8 + (b % 8)] = w[b];
    return o;
  endfunction

  function automatic logic [7:0] m_irq(input int k);
    logic [7:0] v = '0;
    for (int n = 0; n < cfg_nreg[k]; n++) v[n] = (m_st[k][n] != 0);
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int n = 0; n < 8; n++) m_st[k][n] = '0;
      m_rd[k] = '0; m_err[k] = 1'b0;
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      int unsigned sel, idx, win, base, a, n, bitp;
      bit ok;
      sel  = db_data & ((32'd1 << cfg_selw[k]) - 1);
      idx  = db_data >> cfg_selw[k];
      win  = cfg_nar[k] ? 8 : 32;
      ok   = (sel < cfg_nreg[k]) && (idx < win);
      m_err[k] = db_valid && !ok;
      if (rd_en) begin
        base = cfg_nar[k] ? 16 : 4;
        a    = rd_addr;
        if (a >= base && (a % 4) == 0 && (a - base) / 4 < cfg_nreg[k]) begin
          n = (a - base) / 4;
          m_rd[k] = be_swap(m_st[k][n]);
          m_st[k][n] = '0;
        end else begin
          m_rd[k] = '0;
        end
      end
      if (db_valid && ok) begin
        bitp = cfg_nar[k] ? (31 - 8 * sel - idx) : (31 - idx);
        m_st[k][sel][bitp] = 1'b1;
      end
    end
  endtask

  task automatic compare();
    check(cur_tag, "full rd_data",   rd_a, m_rd[0]);
    check(cur_tag, "narrow rd_data", rd_b, m_rd[1]);
    check(cur_tag, "full irq_o",   {24'd0, irq_a}, {24'd0, m_irq(0)});
    check(cur_tag, "narrow irq_o", {24'd0, 4'd0, irq_b}, {24'd0, m_irq(1)});
    check(cur_tag, "full db_err",   {31'd0, err_a}, {31'd0, m_err[0]});
    check(cur_tag, "narrow db_err", {31'd0, err_b}, {31'd0, m_err[1]});
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    db_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ring(input logic [31:0] d);
    db_valid = 1'b1; db_data = d; cycle();
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1'b1; rd_addr = a; cycle();
  endtask

  task automatic ring_rd(input logic [31:0] d, input logic [7:0] a);
    db_valid = 1'b1; db_data = d; rd_en = 1'b1; rd_addr = a; cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; db_valid = 1'b0; db_data = '0; rd_en = 1'b0; rd_addr = '0;
    model_reset();
    // R10: reset state
    cur_tag = "R10";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    repeat (4) cycle();

    // R2: full layout index 0 and last index; same data decodes narrow-side too
    cur_tag = "R2";
    ring(32'h0000_0000);          // sel 0, idx 0
    ring((32'd31 << 3) | 32'd5);  // full: sel 5 idx 31
    ring((32'd7 << 3) | 32'd2);
    rd(8'h04); rd(8'h18); rd(8'h0C);

    // R3: narrow windows for every word, lowest and highest index
    cur_tag = "R3";
    for (int n = 0; n < 4; n++) begin
      ring((32'd0 << 2) | 32'(n));
      ring((32'd7 << 2) | 32'(n));
    end
    for (int n = 0; n < 4; n++) rd(8'(16 + 4 * n));

    // R1: every word of the full instance, distinct indices
    cur_tag = "R1";
    for (int n = 0; n < 8; n++) ring((32'(n * 3) << 3) | 32'(n));
    // R8: lines high until read
    cur_tag = "R8";
    repeat (2) cycle();

    // R4 / R5: walk all addresses, aligned and not
    cur_tag = "R4";
    for (int a = 0; a < 48; a++) rd(8'(a));
    cur_tag = "R5";
    ring((32'd3 << 3) | 32'd1);
    ring((32'd12 << 3) | 32'd1);
    ring((32'd20 << 3) | 32'd1);
    ring((32'd29 << 3) | 32'd1);
    rd(8'h08);

    // R6: read data holds, second read sees cleared word
    cur_tag = "R6";
    ring(32'd9);
    rd(8'h08);
    repeat (3) cycle();
    rd(8'h08);

    // R7: doorbell and clearing read on the same word in one cycle
    cur_tag = "R7";
    ring(32'd0);
    ring_rd((32'd4 << 3), 8'h04);
    rd(8'h04);
    ring_rd((32'd1 << 2) | 32'd2, 8'h18);
    rd(8'h18);

    // R9: out-of-range index and select
    cur_tag = "R9";
    ring(32'd32 << 3);
    ring(32'd8 << 2);
    ring(32'hFFFF_FFFF);
    ring(32'h0001_0000);
    repeat (2) cycle();

    // mixed traffic
    cur_tag = "R1";
    void'($urandom(32'd17));
    for (int i = 0; i < 3000; i++) begin
      db_valid = ($urandom % 2) == 0;
      db_data  = (($urandom % 8) == 0) ? $urandom : ($urandom % 300);
      rd_en    = ($urandom % 3) == 0;
      rd_addr  = 8'($urandom % 56);
      cycle();
    end
    for (int a = 0; a < 48; a++) rd(8'(a));

    finish_run();
  end

endmodule